// File: doc/BRIEF.md
# Descrambler Synchronization Watchdog

This block supervises the lock of a 100BASE-X receive descrambler. The descrambler keeps its lock only while it keeps seeing idle symbols. Once the descrambler reports lock, the watchdog opens a time window and counts the idle-detected strobes that arrive during it. When the count reaches a minimum tally, the window restarts. If the window runs out first, the block emits a one-cycle loss-of-lock pulse, and the descrambler then goes back to hunting for idles.

Two run-time controls shape the window. A length select picks between a short window that meets the standard and a long window that tolerates oversized frames. A disable control suppresses timeouts altogether. At a 25 MHz symbol clock the default terminal counts, 18050 and 50000 cycles, give about 722 us and 2 ms.

The controller has three states. In HUNT the descrambler is not locked and both counters are held clear. In WATCH the window is running. TRIP lasts one cycle and drives the pulse. The transitions are:
- HUNT to WATCH when the lock input is sampled high.
- WATCH to HUNT when the lock input is sampled low.
- WATCH to WATCH with a restart when the idle tally completes.
- WATCH to TRIP when the window expires while the timer is enabled.
- TRIP to HUNT unconditionally.

Top module: `desc_sync_watchdog`

## Requirements
- R1: During and directly after an active-low reset, `lock_lost_o` is 0 and the block is hunting, with both counters clear.
- R2: While `locked_i` is low, `lock_lost_o` stays 0 and `idle_i` strobes are not counted. The window starts on the first clock edge that samples `locked_i` high.
- R3: With `long_sel_i` = 0 and no completed idle tally, `lock_lost_o` rises right after the clock edge that lies SHORT_CYCLES edges after the edge that first sampled `locked_i` high.
- R4: With `long_sel_i` = 1, the same holds with LONG_CYCLES in place of SHORT_CYCLES.
- R5: Each MIN_IDLES sampled idle strobes within a window restart the window and clear the tally. Fewer strobes than MIN_IDLES do not delay the timeout.
- R6: If the idle tally completes on the same edge that the window expires, the restart wins and no pulse is produced.
- R7: `lock_lost_o` is high for exactly one cycle, after which the block is hunting. If `locked_i` is still high, a fresh window starts on the next edge.
- R8: While `timer_dis_i` is 1, no pulse is produced and both counters are held clear. After it returns to 0, a full window elapses before any timeout.
- R9: An edge that samples `locked_i` low returns the block to hunting and discards the elapsed window.
- R10: `long_sel_i` acts at once. If the elapsed count already reaches the newly selected window, the timeout occurs on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| locked_i | input | 1 | Descrambler reports lock; low holds the watchdog in HUNT |
| idle_i | input | 1 | One-cycle strobe per idle symbol detected |
| long_sel_i | input | 1 | 0 = short window, 1 = long window |
| timer_dis_i | input | 1 | 1 = timeouts suppressed |
| lock_lost_o | output | 1 | One-cycle pulse: synchronization lost, restart idle search |

## Verification
A wrong window count or a wrong limit selection shows at the port as a timeout pulse that comes too early or too late. Each timeout is measured against the exact edge number, so an error of a single cycle in either window is caught on the first expiry. A tally that fails to clear or to restart shows up as a pulse where none is expected, or as a missing pulse, within one window length. A stuck state shows as a pulse wider than one cycle, or as a missing restart on the cycle right after a trip.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
    typedef enum logic [1:0] {
        DSW_HUNT  = 2'd0,
        DSW_WATCH = 2'd1,
        DSW_TRIP  = 2'd2
    } dsw_state_e;

    localparam int DSW_SHORT_DEF = 18050;
    localparam int DSW_LONG_DEF  = 50000;
    localparam int DSW_IDLES_DEF = 16;
endpackage

// File: rtl/dsw_window_timer.sv
module dsw_window_timer #(
    parameter int SHORT_CYCLES = dsw_pkg::DSW_SHORT_DEF,
    parameter int LONG_CYCLES  = dsw_pkg::DSW_LONG_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic long_sel,
    output logic expired
);
    localparam int W = $clog2(LONG_CYCLES + 1);
    localparam logic [W-1:0] SHORT_LAST = W'(SHORT_CYCLES - 1);
    localparam logic [W-1:0] LONG_LAST  = W'(LONG_CYCLES - 1);

    logic [W-1:0] elapsed;
    logic [W-1:0] last;

    always_comb begin
        last    = long_sel ? LONG_LAST : SHORT_LAST;
        expired = (elapsed >= last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        elapsed <= '0;
        else if (clear)    elapsed <= '0;
        else if (!expired) elapsed <= elapsed + 1'b1;
    end

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (elapsed == '0));
    // R4
    bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed <= LONG_LAST);
endmodule

// File: rtl/dsw_idle_tally.sv
module dsw_idle_tally #(
    parameter int MIN_IDLES = dsw_pkg::DSW_IDLES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic idle,
    output logic enough
);
    localparam int TW = $clog2(MIN_IDLES + 1);
    localparam logic [TW-1:0] TALLY_LAST = TW'(MIN_IDLES - 1);

    logic [TW-1:0] tally;

    assign enough = !clear && idle && (tally == TALLY_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tally <= '0;
        else if (clear)  tally <= '0;
        else if (enough) tally <= '0;
        else if (idle)   tally <= tally + 1'b1;
    end

    // R2
    tally_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (tally == '0));
    // R5
    tally_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tally <= TALLY_LAST);
endmodule

// File: rtl/desc_sync_watchdog.sv
module desc_sync_watchdog
    import dsw_pkg::*;
#(
    parameter int SHORT_CYCLES = DSW_SHORT_DEF,
    parameter int LONG_CYCLES  = DSW_LONG_DEF,
    parameter int MIN_IDLES    = DSW_IDLES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic locked_i,
    input  logic idle_i,
    input  logic long_sel_i,
    input  logic timer_dis_i,
    output logic lock_lost_o
);
    dsw_state_e state, state_nx;
    logic watching;
    logic hold_clear;
    logic win_clear;
    logic win_expired;
    logic idles_done;

    assign watching   = (state == DSW_WATCH);
    assign hold_clear = !watching || timer_dis_i;
    assign win_clear  = hold_clear || idles_done;

    dsw_window_timer #(
        .SHORT_CYCLES(SHORT_CYCLES),
        .LONG_CYCLES (LONG_CYCLES)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (win_clear),
        .long_sel(long_sel_i),
        .expired (win_expired)
    );

    dsw_idle_tally #(
        .MIN_IDLES(MIN_IDLES)
    ) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (hold_clear),
        .idle  (idle_i),
        .enough(idles_done)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            DSW_HUNT:  if (locked_i) state_nx = DSW_WATCH;
            DSW_WATCH: begin
                if (!locked_i)                         state_nx = DSW_HUNT;
                else if (idles_done)                   state_nx = DSW_WATCH;
                else if (win_expired && !timer_dis_i)  state_nx = DSW_TRIP;
            end
            DSW_TRIP:  state_nx = DSW_HUNT;
            default:   state_nx = DSW_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DSW_HUNT;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            DSW_TRIP: lock_lost_o = 1'b1;
            default:  lock_lost_o = 1'b0;
        endcase
    end

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lost_o |=> !lock_lost_o);
    // R8
    dis_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DSW_TRIP) |-> $past(!timer_dis_i));
    // R9
    unlock_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(locked_i) |-> (state == DSW_HUNT));
    // R2
    watch_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DSW_WATCH) |-> $past(locked_i));
    // R7
    trip_from_watch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DSW_TRIP) |-> ($past(state) == DSW_WATCH));
endmodule

// File: tb/sim_desc_sync_watchdog.sv
module sim_desc_sync_watchdog;
    localparam int SHORT = 30;
    localparam int LONG  = 80;
    localparam int MINI  = 4;
    localparam int NVEC  = 7;
    // columns: long_sel, idle period (0 = none), cycles to run, expected first pulse (-1 = none)
    localparam int VEC [NVEC][4] = '{
        '{0, 0,  60, 31},
        '{1, 0, 120, 81},
        '{0, 5, 200, -1},
        '{1, 15, 300, -1},
        '{0, 15, 60, 31},
        '{1, 25, 120, 81},
        '{0, 7, 200, -1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic locked = 1'b0;
    logic idle = 1'b0;
    logic long_sel = 1'b0;
    logic dis = 1'b0;
    logic lock_lost;

    int checks = 0;
    int failures = 0;
    int k, first, pulses;
    bit prev, wide;

    always #5 clk = ~clk;

    desc_sync_watchdog #(
        .SHORT_CYCLES(SHORT),
        .LONG_CYCLES (LONG),
        .MIN_IDLES   (MINI)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .locked_i   (locked),
        .idle_i     (idle),
        .long_sel_i (long_sel),
        .timer_dis_i(dis),
        .lock_lost_o(lock_lost)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        k++;
        idle = 1'b0;
        if (lock_lost) begin
            pulses++;
            if (first < 0) first = k;
            if (prev) wide = 1'b1;
        end
        prev = lock_lost;
    endtask

    task automatic clear_meas();
        k = 0; first = -1; pulses = 0; prev = 1'b0; wide = 1'b0;
    endtask

    task automatic start_case(input bit sel, input bit d);
        locked = 1'b0; idle = 1'b0; long_sel = sel; dis = d;
        tick(); tick();
        clear_meas();
        locked = 1'b1;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_meas();
        // R1 reset state
        repeat (3) @(negedge clk);
        check(lock_lost == 1'b0, "R1 pulse low in reset", int'(lock_lost), 0);
        rst_n = 1'b1;
        locked = 1'b0;
        tick(); tick();
        check(lock_lost == 1'b0, "R1 pulse low after reset", int'(lock_lost), 0);

        // table walk: R3 R4 R5 R7
        for (int v = 0; v < NVEC; v++) begin
            start_case(VEC[v][0][0], 1'b0);
            for (int c = 0; c < VEC[v][2]; c++) begin
                tick();
                if (VEC[v][1] != 0 && (k % VEC[v][1]) == 0) idle = 1'b1;
            end
            if (VEC[v][3] < 0)
                check(pulses == 0, "R5 no timeout with steady idles", pulses, 0);
            else
                check(first == VEC[v][3], VEC[v][0] != 0 ? "R4 long window edge" : "R3 short window edge",
                      first, VEC[v][3]);
            check(!wide, "R7 pulse width one cycle", int'(wide), 0);
        end

        // R7: rewatch starts on the next edge, second pulse one window later
        start_case(1'b0, 1'b0);
        repeat (70) tick();
        check(pulses == 2, "R7 second window follows trip", pulses, 2);

        // R2: idles while unlocked are ignored; R5: fewer than MIN idles do not restart
        locked = 1'b0;
        for (int c = 0; c < 10; c++) begin tick(); idle = 1'b1; end
        tick();
        clear_meas();
        check(lock_lost == 1'b0, "R2 no pulse while unlocked", int'(lock_lost), 0);
        locked = 1'b1;
        for (int c = 0; c < 40; c++) begin
            tick();
            if (k >= 2 && k <= 4) idle = 1'b1;
        end
        check(first == SHORT + 1, "R2 R5 window from lock, partial tally", first, SHORT + 1);

        // R6: tally completes on the expiry edge
        start_case(1'b0, 1'b0);
        for (int c = 0; c < 70; c++) begin
            tick();
            if (k >= 27 && k <= 30) idle = 1'b1;
        end
        check(first == 61, "R6 restart wins over expiry", first, 61);

        // R8: disable holds off timeouts, then a full window after release
        start_case(1'b0, 1'b1);
        for (int c = 0; c < 140; c++) begin
            tick();
            if (k == 100) dis = 1'b0;
        end
        check(first == 130, "R8 disable then full window", first, 130);

        // R9: lock drop discards the elapsed window
        start_case(1'b0, 1'b0);
        for (int c = 0; c < 60; c++) begin
            tick();
            if (k == 20) locked = 1'b0;
            if (k == 25) locked = 1'b1;
        end
        check(first == 56, "R9 relock restarts window", first, 56);

        // R10: switch to short window after it has already elapsed
        start_case(1'b1, 1'b0);
        for (int c = 0; c < 60; c++) begin
            tick();
            if (k == 50) long_sel = 1'b0;
        end
        check(first == 51, "R10 select change trips next edge", first, 51);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule